// File: doc/BRIEF.md
# Double-Rate Burst-of-Two Memory Write Port

This block is the write half of a synchronous static memory whose input and output sides are separate. A write command is taken on a rising edge of the main clock while the active-low write select is low. Each command carries a two-word burst. The first word and its byte-lane enables are captured on that same rising edge. The second word and its enables are captured on the next rising edge of the complementary clock. The write address only follows, on the main-clock edge after the command.

Once the address arrives, both words are stored together. The first goes to the array location formed by the address with a low burst bit appended. The second goes to the location with a high burst bit appended. Each 9-bit lane has its own active-low enable, and a disabled lane keeps its old contents. Commands may be issued on every main-clock cycle. A cycle with write select high is a deselect cycle: the port ignores the data offered in it, but a burst already under way still completes.

A combinational read-back port exposes any array word so the stored contents can be checked. The word width is set by the lane count: two lanes give 18 bits and four lanes give 36 bits.

Top module: `ddr_wr_port`

## Requirements
- R1: While reset is low, no write is pending and every array word reads back as zero.
- R2: A write command is accepted when `wrSelN` is low (active low) at a rising edge of `clkK`.
- R3: The first burst word and its lane enables are sampled from `wrData` and `laneEnN` on the same rising `clkK` edge that accepts the command.
- R4: The second burst word and its lane enables are sampled from `wrData` and `laneEnN` on the first rising edge of `clkKn` after the command edge.
- R5: `wrAddr` is sampled on the rising `clkK` edge that follows the command edge. At that edge the first word is stored at read-back address {wrAddr,0} and the second word at {wrAddr,1}.
- R6: Commands may be issued on consecutive `clkK` edges, and each one is stored correctly.
- R7: When `wrSelN` is high at a rising `clkK` edge, the data and enables offered in that cycle do not change the array.
- R8: `laneEnN` bit i, when low, enables writing of bits 9i to 9i+8 of its beat's word. When the bit is high, those bits keep their previous contents.
- R9: A burst whose command was accepted completes both words, even if the port is deselected on the next `clkK` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkK | input | 1 | Main clock; commands, first beat and address sampled on its rising edge |
| clkKn | input | 1 | Complementary clock; second beat sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrSelN | input | 1 | Active-low write select |
| wrAddr | input | ADDR_W | Burst address, presented one cycle after the command |
| wrData | input | 9*LANES | Data beat input, double data rate |
| laneEnN | input | LANES | Active-low lane write enables, one set per beat |
| rdAddr | input | ADDR_W+1 | Read-back address: {burst address, burst bit} |
| rdData | output | 9*LANES | Array word at rdAddr |

## Verification
The assertions assume that `clkKn` is the exact inverse of `clkK`. They also assume that reset is held across at least one `clkK` rising edge, and that `rdAddr` moves only when the bench reads, never in the middle of a write. The stimulus meets these conditions as follows. The bench derives `clkKn` by inversion. It changes every input a fixed offset after a clock edge, so no input ever changes on a sampling edge. It changes `rdAddr` only while `wrSelN` is held high.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;
  localparam int unsigned LANE_W = 9;

  typedef struct packed {
    logic takeFirst;   // capture first beat on this clkK edge
    logic takeSecond;  // capture second beat on the coming clkKn edge
    logic commit;      // store burst on this clkK edge
  } wrStrobe_t;
endpackage

// File: rtl/ddr_wr_ctrl.sv
module ddr_wr_ctrl
  import ddr_wr_pkg::*;
(
  input  logic       clkK,
  input  logic       rstN,
  input  logic       wrSelN,
  output wrStrobe_t  strobe
);
  logic cmdPend;

  always_ff @(posedge clkK or negedge rstN) begin
    if (!rstN) cmdPend <= 1'b0;
    else       cmdPend <= ~wrSelN;
  end

  always_comb begin
    strobe.takeFirst  = ~wrSelN;
    strobe.takeSecond = cmdPend;
    strobe.commit     = cmdPend;
  end
endmodule

// File: rtl/ddr_wr_datapath.sv
module ddr_wr_datapath
  import ddr_wr_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                       clkK,
  input  logic                       clkKn,
  input  logic                       rstN,
  input  wrStrobe_t                  strobe,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [LANES*LANE_W-1:0]    wrData,
  input  logic [LANES-1:0]           laneEnN,
  input  logic [ADDR_W:0]            rdAddr,
  output logic [LANES*LANE_W-1:0]    rdData
);
  localparam int unsigned WORD_W = LANES * LANE_W;
  localparam int unsigned DEPTH  = 2 ** (ADDR_W + 1);

  logic [WORD_W-1:0] firstQ, secondQ;
  logic [LANES-1:0]  firstEnN, secondEnN;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clkK or negedge rstN) begin
    if (!rstN) begin
      firstQ   <= '0;
      firstEnN <= '1;
    end else if (strobe.takeFirst) begin
      firstQ   <= wrData;
      firstEnN <= laneEnN;
    end
  end

  always_ff @(posedge clkKn or negedge rstN) begin
    if (!rstN) begin
      secondQ   <= '0;
      secondEnN <= '1;
    end else if (strobe.takeSecond) begin
      secondQ   <= wrData;
      secondEnN <= laneEnN;
    end
  end

  always_ff @(posedge clkK or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (strobe.commit) begin
      for (int l = 0; l < LANES; l++) begin
        if (!firstEnN[l])
          mem[{wrAddr, 1'b0}][l*LANE_W +: LANE_W] <= firstQ[l*LANE_W +: LANE_W];
        if (!secondEnN[l])
          mem[{wrAddr, 1'b1}][l*LANE_W +: LANE_W] <= secondQ[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdData = mem[rdAddr];
endmodule

// File: rtl/ddr_wr_port.sv
module ddr_wr_port
  import ddr_wr_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clkK,
  input  logic                    clkKn,
  input  logic                    rstN,
  input  logic                    wrSelN,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES*9-1:0]      wrData,
  input  logic [LANES-1:0]        laneEnN,
  input  logic [ADDR_W:0]         rdAddr,
  output logic [LANES*9-1:0]      rdData
);
  wrStrobe_t strobe;

  ddr_wr_ctrl u_ctrl (
    .clkK   (clkK),
    .rstN   (rstN),
    .wrSelN (wrSelN),
    .strobe (strobe)
  );

  ddr_wr_datapath #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dp (
    .clkK    (clkK),
    .clkKn   (clkKn),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .laneEnN (laneEnN),
    .rdAddr  (rdAddr),
    .rdData  (rdData)
  );
endmodule

// File: rtl/ddr_wr_port_chk.sv
module ddr_wr_port_chk
  import ddr_wr_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input logic                 clkK,
  input logic                 rstN,
  input logic                 wrSelN,
  input wrStrobe_t            strobe,
  input logic [ADDR_W:0]      rdAddr,
  input logic [LANES*9-1:0]   rdData
);
  initial begin
    assert_lane_count_R8: assert (LANES == 2 || LANES == 4);
  end

  assert_reset_idle_R1: assert property (@(posedge clkK) !rstN |-> !strobe.commit);

  assert_cmd_commit_R2: assert property (@(posedge clkK) disable iff (!rstN)
    !wrSelN |=> strobe.commit);

  assert_deselect_quiet_R7: assert property (@(posedge clkK) disable iff (!rstN)
    wrSelN |=> !strobe.commit);

  assert_array_hold_R7: assert property (@(posedge clkK) disable iff (!rstN)
    !strobe.commit |=> (rdAddr != $past(rdAddr) || rdData == $past(rdData)));

  assert_second_armed_R4: assert property (@(posedge clkK) disable iff (!rstN)
    !wrSelN |=> strobe.takeSecond);
endmodule

bind ddr_wr_port ddr_wr_port_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
  .clkK   (clkK),
  .rstN   (rstN),
  .wrSelN (wrSelN),
  .strobe (strobe),
  .rdAddr (rdAddr),
  .rdData (rdData)
);

// File: tb/ddr_wr_port_tb.sv
`timescale 1ns/1ps
module ddr_wr_port_tb;
  localparam int LANES  = 4;
  localparam int ADDR_W = 4;
  localparam int WW     = LANES * 9;
  localparam int NV     = 6;

  localparam logic [ADDR_W-1:0] V_ADDR [NV] = '{4'h1, 4'h2, 4'h1, 4'hF, 4'h2, 4'h0};
  localparam logic [WW-1:0] V_D0 [NV] = '{36'h1_2345_6789, 36'hF_FFFF_FFFF, 36'h5_5555_5555,
                                          36'h8_0000_0000, 36'h9_9999_9999, 36'hC_0FFE_E123};
  localparam logic [LANES-1:0] V_M0 [NV] = '{4'h0, 4'h0, 4'h5, 4'h7, 4'hF, 4'h0};
  localparam logic [WW-1:0] V_D1 [NV] = '{36'hA_BCDE_F012, 36'h0_0000_0001, 36'h3_3333_3333,
                                          36'h0_0000_01FF, 36'h7_7777_7777, 36'h1_1111_1111};
  localparam logic [LANES-1:0] V_M1 [NV] = '{4'h0, 4'h0, 4'hA, 4'hE, 4'hC, 4'h3};

  logic clkK = 1'b0;
  logic clkKn;
  logic rstN = 1'b0;
  logic wrSelN = 1'b1;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [WW-1:0] wrData = '0;
  logic [LANES-1:0] laneEnN = '1;
  logic [ADDR_W:0] rdAddr = '0;
  logic [WW-1:0] rdData;

  int total = 0;
  int bad = 0;
  logic [WW-1:0] model [2**(ADDR_W+1)];

  always #2.5 clkK = ~clkK;
  assign clkKn = ~clkK;

  ddr_wr_port #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dut (
    .clkK(clkK), .clkKn(clkKn), .rstN(rstN), .wrSelN(wrSelN), .wrAddr(wrAddr),
    .wrData(wrData), .laneEnN(laneEnN), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic modelWrite(input logic [ADDR_W-1:0] a, input logic b,
                            input logic [WW-1:0] d, input logic [LANES-1:0] m);
    for (int l = 0; l < LANES; l++)
      if (!m[l]) model[{a, b}][l*9 +: 9] = d[l*9 +: 9];
  endtask

  // one clkK cycle: command/first beat, then second beat; address is for the previous command
  task automatic drive(input logic ws, input logic [WW-1:0] d0, input logic [LANES-1:0] m0,
                       input logic [WW-1:0] d1, input logic [LANES-1:0] m1,
                       input logic [ADDR_W-1:0] a);
    @(posedge clkKn); #1;
    wrSelN = ws; wrData = d0; laneEnN = m0; wrAddr = a;
    @(posedge clkK); #1;
    wrData = d1; laneEnN = m1;
  endtask

  task automatic readChk(input string tag, input logic [ADDR_W:0] a, input logic [WW-1:0] exp);
    rdAddr = a;
    #0.2;
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL %s addr=%0h actual=%h expected=%h", tag, a, rdData, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 2**(ADDR_W+1); w++) model[w] = '0;
    repeat (3) @(posedge clkK);
    // R1: array zero while in reset
    readChk("R1", 5'h03, '0);
    readChk("R1", 5'h1F, '0);
    #1 rstN = 1'b1;

    // R2 R3 R4 R5 R6 R8: back-to-back table writes
    for (int i = 0; i < NV; i++) begin
      drive(1'b0, V_D0[i], V_M0[i], V_D1[i], V_M1[i], (i == 0) ? '0 : V_ADDR[i-1]);
      modelWrite(V_ADDR[i], 1'b0, V_D0[i], V_M0[i]);
      modelWrite(V_ADDR[i], 1'b1, V_D1[i], V_M1[i]);
    end
    drive(1'b1, '1, '0, '1, '0, V_ADDR[NV-1]);
    for (int i = 0; i < NV; i++) begin
      readChk("R5_R6_R8 beat0", {V_ADDR[i], 1'b0}, model[{V_ADDR[i], 1'b0}]);
      readChk("R5_R6_R8 beat1", {V_ADDR[i], 1'b1}, model[{V_ADDR[i], 1'b1}]);
    end
    // R8: fully masked beat left address 2 first word as written by entry 1
    readChk("R8 all lanes masked", 5'h04, 36'hF_FFFF_FFFF);

    // R7: deselected cycles with lanes enabled must not write
    drive(1'b1, 36'h0_DEAD_BEEF, '0, 36'h0_BAD0_BAD0, '0, 4'h1);
    drive(1'b1, 36'h0_DEAD_BEEF, '0, 36'h0_BAD0_BAD0, '0, 4'h1);
    drive(1'b1, '0, '0, '0, '0, 4'h1);
    readChk("R7 deselect", 5'h02, model[5'h02]);
    readChk("R7 deselect", 5'h03, model[5'h03]);

    // R9: write followed immediately by deselect still completes
    drive(1'b0, 36'h2_4681_3579, '0, 36'hE_CA86_4201, '0, 4'h0);
    drive(1'b1, 36'h0_0000_0000, '0, 36'h0_0000_0000, '0, 4'h6);
    readChk("R9 beat0", 5'h0C, 36'h2_4681_3579);
    readChk("R9 beat1", 5'h0D, 36'hE_CA86_4201);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule